// File: doc/BRIEF.md
# I2C Master Bus-Condition Sequencer

This block converts software requests into START, repeated START and STOP conditions on an I2C bus while the controller is master. Software writes request bits through a write strobe. The block records each request and drives the open-drain pull-down enables for SDA and SCL, one phase per prescaled timing tick. It clears the request bit by itself once the condition is complete. Byte transfer is handled elsewhere. Between conditions, this block only holds SCL low while the bus is owned.

Requests are mutually exclusive. A write that asks for both conditions is discarded. A request that arrives while the other kind is pending is dropped. A START that cannot begin because another master holds the bus can be cancelled by a tick-based timeout, which raises its own interrupt pulse. When the controller is disabled or leaves master mode, every request is wiped and both lines are released.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset, both request bits read 0, both line pull-down outputs are 0 (released), and both interrupt pulses are 0.
- R2: While the controller is active (master and enable both 1), a write with the start bit 1 and the stop bit 0 sets the START request when no STOP is pending. A write with the stop bit 1 and the start bit 0 sets the STOP request when no START is pending. A write bit of 0 leaves its request unchanged.
- R3: A single write with both the start and stop bits at 1 clears both requests to 0.
- R4: A start bit written while STOP is pending is dropped, and START stays 0. A stop bit written while START is pending is dropped, and STOP stays 0. Pending means the register value before the write's clock edge, including the edge at which that request completes.
- R5: From the idle (not owned) state, a START request begins at a tick on which bus_busy is 0. The lines then go through SDA low with SCL released for one tick, then both low for one tick, then the owned state (SCL low, SDA released). The START request reads 0 from the cycle the owned state is entered.
- R6: From the owned state, a START request first releases both lines for one tick and then runs the R5 sequence (repeated START).
- R7: From the owned state, a STOP request drives both lines low for one tick, then releases SCL for one tick, then releases both lines, and the STOP request reads 0 at that point. A STOP pending while the bus is not owned clears at the next tick with no line activity.
- R8: When start_irq_en is 1, start_irq pulses high for one cycle in the same cycle that the START request first reads 0 after a completed START.
- R9: With to_en 1, each tick on which a pending START waits in the idle state because bus_busy is 1 is counted. On the count that reaches to_limit (a limit of 0 acts as 1), the START request is cleared and, if to_irq_en is 1, to_irq pulses for one cycle. The count restarts from 0 whenever no request is pending. With to_en 0, no timeout occurs.
- R10: When master or enable is 0, both requests are 0, writes have no effect, and the sequencer returns to idle with both lines released.
- R11: The line outputs change only at clock edges where tick was 1 or the controller was inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Request register write strobe |
| wr_start | input | 1 | Written value of the START request bit |
| wr_stop | input | 1 | Written value of the STOP request bit |
| master | input | 1 | Master mode select |
| enable | input | 1 | Controller enable |
| bus_busy | input | 1 | Bus held by another master |
| tick | input | 1 | Prescaled timing tick, one phase per tick |
| to_en | input | 1 | Timeout enable |
| to_limit | input | TO_W | Timeout limit in waiting ticks |
| start_irq_en | input | 1 | START interrupt enable |
| to_irq_en | input | 1 | Timeout interrupt enable |
| sda_low | output | 1 | Pull SDA low when 1 |
| scl_low | output | 1 | Pull SCL low when 1 |
| start_req | output | 1 | Pending START request (readable) |
| stop_req | output | 1 | Pending STOP request (readable) |
| start_irq | output | 1 | START completed pulse |
| to_irq | output | 1 | Timeout pulse |

## Verification
A START can complete at the same clock edge where software writes the stop bit. The rejection rule then compares against the still-set START request, so the STOP write must be dropped even though START reads 0 one cycle later. The bench provokes this on purpose: it drives a tick that ends a repeated START together with a stop-bit write, and then checks that both requests read 0. Random traffic also hits the same collision, and a timeout coinciding with a fresh write, and judges each against a cycle model in the bench.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    GS_IDLE   = 3'd0,
    GS_OWN    = 3'd1,
    GS_RS_REL = 3'd2,
    GS_ST_SDA = 3'd3,
    GS_ST_SCL = 3'd4,
    GS_SP_LOW = 3'd5,
    GS_SP_SCL = 3'd6
  } gen_state_e;

  typedef struct packed {
    logic sda_low;
    logic scl_low;
  } line_drv_t;

  function automatic line_drv_t drive_of(input gen_state_e st);
    line_drv_t d;
    d.sda_low = (st == GS_ST_SDA) || (st == GS_ST_SCL) ||
                (st == GS_SP_LOW) || (st == GS_SP_SCL);
    d.scl_low = (st == GS_OWN) || (st == GS_ST_SCL) || (st == GS_SP_LOW);
    return d;
  endfunction

endpackage

// File: rtl/i2c_seq_req.sv
module i2c_seq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic wr_en,
  input  logic wr_start,
  input  logic wr_stop,
  input  logic done_start,
  input  logic done_stop,
  input  logic abort,
  output logic start_q,
  output logic stop_q
);

  logic start_nx;
  logic stop_nx;

  always_comb begin
    start_nx = start_q & ~done_start & ~abort;
    stop_nx  = stop_q  & ~done_stop  & ~abort;
    if (wr_en) begin
      if (wr_start && wr_stop) begin
        start_nx = 1'b0;
        stop_nx  = 1'b0;
      end else if (wr_start && !stop_q) begin
        start_nx = 1'b1;
      end else if (wr_stop && !start_q) begin
        stop_nx = 1'b1;
      end
    end
    if (!active) begin
      start_nx = 1'b0;
      stop_nx  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else begin
      start_q <= start_nx;
      stop_q  <= stop_nx;
    end
  end

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_q && stop_q)); // R4
  AST_BOTH_REJECTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_start && wr_stop |=> !start_q && !stop_q); // R3
  AST_INACTIVE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !start_q && !stop_q); // R10
  AST_START_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_start && !wr_stop && stop_q |=> !start_q); // R4

endmodule

// File: rtl/i2c_seq_gen.sv
module i2c_seq_gen
  import i2c_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic bus_busy,
  input  logic start_q,
  input  logic stop_q,
  output logic sda_low,
  output logic scl_low,
  output logic done_start,
  output logic done_stop,
  output logic idle
);

  gen_state_e state_q;
  gen_state_e state_nx;
  line_drv_t  drv;

  always_comb begin
    state_nx   = state_q;
    done_start = 1'b0;
    done_stop  = 1'b0;
    if (!active) begin
      state_nx = GS_IDLE;
    end else if (tick) begin
      case (state_q)
        GS_IDLE: begin
          if (start_q && !bus_busy) begin
            state_nx = GS_ST_SDA;
          end else if (stop_q) begin
            done_stop = 1'b1;
          end
        end
        GS_OWN: begin
          if (start_q) begin
            state_nx = GS_RS_REL;
          end else if (stop_q) begin
            state_nx = GS_SP_LOW;
          end
        end
        GS_RS_REL: state_nx = GS_ST_SDA;
        GS_ST_SDA: state_nx = GS_ST_SCL;
        GS_ST_SCL: begin
          state_nx   = GS_OWN;
          done_start = 1'b1;
        end
        GS_SP_LOW: state_nx = GS_SP_SCL;
        GS_SP_SCL: begin
          state_nx  = GS_IDLE;
          done_stop = 1'b1;
        end
        default: state_nx = GS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GS_IDLE;
    end else begin
      state_q <= state_nx;
    end
  end

  assign drv     = drive_of(state_q);
  assign sda_low = drv.sda_low;
  assign scl_low = drv.scl_low;
  assign idle    = (state_q == GS_IDLE);

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    active && !tick |=> $stable(sda_low) && $stable(scl_low)); // R11
  AST_START_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    idle && bus_busy |=> !sda_low && !scl_low); // R5
  AST_OWN_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    done_start |=> scl_low || !active); // R5

endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            active,
  input  logic            to_en,
  input  logic [TO_W-1:0] limit,
  input  logic            pending,
  input  logic            waiting,
  input  logic            tick,
  output logic            expire
);

  localparam int CW = TO_W + 1;

  logic [TO_W-1:0] cnt_q;
  logic [TO_W-1:0] cnt_nx;
  logic [CW-1:0]   cnt_inc;
  logic [CW-1:0]   lim_eff;
  logic            step;

  assign lim_eff = (limit == '0) ? CW'(1) : {1'b0, limit};
  assign cnt_inc = {1'b0, cnt_q} + CW'(1);
  assign step    = active && to_en && waiting && tick;
  assign expire  = step && (cnt_inc >= lim_eff);

  always_comb begin
    cnt_nx = cnt_q;
    if (!active || !to_en || !pending || expire) begin
      cnt_nx = '0;
    end else if (step) begin
      cnt_nx = cnt_inc[TO_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end

  AST_CNT_CLEARED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> cnt_q == '0); // R9
  AST_NO_EXPIRE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !to_en |-> !expire); // R9

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
  parameter int TO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_start,
  input  logic            wr_stop,
  input  logic            master,
  input  logic            enable,
  input  logic            bus_busy,
  input  logic            tick,
  input  logic            to_en,
  input  logic [TO_W-1:0] to_limit,
  input  logic            start_irq_en,
  input  logic            to_irq_en,
  output logic            sda_low,
  output logic            scl_low,
  output logic            start_req,
  output logic            stop_req,
  output logic            start_irq,
  output logic            to_irq
);

  logic rst_meta;
  logic rst_sync;
  logic active;
  logic done_start;
  logic done_stop;
  logic gen_idle;
  logic expire;
  logic waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign active  = master && enable;
  assign waiting = gen_idle && bus_busy && start_req;

  i2c_seq_req u_req (
    .clk        (clk),
    .rst_n      (rst_sync),
    .active     (active),
    .wr_en      (wr_en),
    .wr_start   (wr_start),
    .wr_stop    (wr_stop),
    .done_start (done_start),
    .done_stop  (done_stop),
    .abort      (expire),
    .start_q    (start_req),
    .stop_q     (stop_req)
  );

  i2c_seq_gen u_gen (
    .clk        (clk),
    .rst_n      (rst_sync),
    .active     (active),
    .tick       (tick),
    .bus_busy   (bus_busy),
    .start_q    (start_req),
    .stop_q     (stop_req),
    .sda_low    (sda_low),
    .scl_low    (scl_low),
    .done_start (done_start),
    .done_stop  (done_stop),
    .idle       (gen_idle)
  );

  i2c_seq_timer #(.TO_W(TO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_sync),
    .active  (active),
    .to_en   (to_en),
    .limit   (to_limit),
    .pending (start_req || stop_req),
    .waiting (waiting),
    .tick    (tick),
    .expire  (expire)
  );

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      start_irq <= 1'b0;
      to_irq    <= 1'b0;
    end else begin
      start_irq <= done_start && start_irq_en;
      to_irq    <= expire && to_irq_en;
    end
  end

  AST_START_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_sync)
    start_irq |=> !start_irq); // R8
  AST_TIMEOUT_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync)
    expire && !(wr_en && wr_start) |=> !start_req); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_sync)
    done_stop |=> !sda_low && !scl_low); // R7

endmodule

// File: tb/test_i2c_cond_seq.sv
module test_i2c_cond_seq;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, wr_start, wr_stop, master, enable, bus_busy, tick;
  logic       to_en, start_irq_en, to_irq_en;
  logic [7:0] to_limit;
  logic       sda_low, scl_low, start_req, stop_req, start_irq, to_irq;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  i2c_cond_seq #(.TO_W(8)) i_i2c_cond_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_start(wr_start),
    .wr_stop(wr_stop), .master(master), .enable(enable),
    .bus_busy(bus_busy), .tick(tick), .to_en(to_en), .to_limit(to_limit),
    .start_irq_en(start_irq_en), .to_irq_en(to_irq_en),
    .sda_low(sda_low), .scl_low(scl_low), .start_req(start_req),
    .stop_req(stop_req), .start_irq(start_irq), .to_irq(to_irq)
  );

  // bench model: 0 idle, 1 owned, 2 rs release, 3 start sda, 4 start scl,
  // 5 stop low, 6 stop scl
  int m_st, m_cnt;
  logic m_s, m_p, m_sirq, m_tirq;

  function automatic logic exp_sda(input int st);
    return (st == 3) || (st == 4) || (st == 5) || (st == 6);
  endfunction

  function automatic logic exp_scl(input int st);
    return (st == 1) || (st == 4) || (st == 5);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_s = 0; m_p = 0; m_sirq = 0; m_tirq = 0;
    end else begin
      logic act, wait_c, exp_c, d_s, d_p, s_n, p_n;
      int st_n, lim, cnt_n;
      act    = master && enable;
      lim    = (to_limit == 0) ? 1 : int'(to_limit);
      wait_c = (m_st == 0) && bus_busy && m_s;
      exp_c  = act && to_en && wait_c && tick && (m_cnt + 1 >= lim);
      d_s = 0; d_p = 0; st_n = m_st;
      if (!act) st_n = 0;
      else if (tick) begin
        case (m_st)
          0: if (m_s && !bus_busy) st_n = 3; else if (m_p) d_p = 1;
          1: if (m_s) st_n = 2; else if (m_p) st_n = 5;
          2: st_n = 3;
          3: st_n = 4;
          4: begin st_n = 1; d_s = 1; end
          5: st_n = 6;
          default: begin st_n = 0; d_p = 1; end
        endcase
      end
      s_n = m_s && !d_s && !exp_c;
      p_n = m_p && !d_p && !exp_c;
      if (wr_en) begin
        if (wr_start && wr_stop) begin s_n = 0; p_n = 0; end
        else if (wr_start && !m_p) s_n = 1;
        else if (wr_stop && !m_s) p_n = 1;
      end
      if (!act) begin s_n = 0; p_n = 0; end
      cnt_n = m_cnt;
      if (!act || !to_en || !(m_s || m_p) || exp_c) cnt_n = 0;
      else if (wait_c && tick) cnt_n = m_cnt + 1;
      m_sirq = d_s && start_irq_en;
      m_tirq = exp_c && to_irq_en;
      m_st = st_n; m_s = s_n; m_p = p_n; m_cnt = cnt_n;
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic cmp_model;
    chk("R5 R6 R7 sda_low", int'(sda_low), int'(exp_sda(m_st)));
    chk("R5 R6 R7 scl_low", int'(scl_low), int'(exp_scl(m_st)));
    chk("R2 start_req", int'(start_req), int'(m_s));
    chk("R2 stop_req", int'(stop_req), int'(m_p));
    chk("R8 start_irq", int'(start_irq), int'(m_sirq));
    chk("R9 to_irq", int'(to_irq), int'(m_tirq));
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic do_write(input logic s, input logic p);
    wr_en = 1; wr_start = s; wr_stop = p;
    step();
    wr_en = 0; wr_start = 0; wr_stop = 0;
  endtask

  task automatic do_tick;
    tick = 1;
    step();
    tick = 0;
  endtask

  task automatic lines(input string tag, input int s, input int c);
    chk(tag, int'(sda_low), s);
    chk(tag, int'(scl_low), c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got 0 expected 1 (run did not end)");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c5e_0917));
    rst_n = 0; wr_en = 0; wr_start = 0; wr_stop = 0; master = 0; enable = 0;
    bus_busy = 0; tick = 0; to_en = 0; to_limit = 8'd3;
    start_irq_en = 1; to_irq_en = 1;
    repeat (3) @(negedge clk);
    chk("R1 start_req", int'(start_req), 0);
    chk("R1 stop_req", int'(stop_req), 0);
    lines("R1 lines", 0, 0);
    chk("R1 irqs", int'(start_irq) + int'(to_irq), 0);
    rst_n = 1;
    repeat (4) step();
    master = 1; enable = 1;
    step();

    do_write(1, 1);
    chk("R3 start_req", int'(start_req), 0);
    chk("R3 stop_req", int'(stop_req), 0);

    do_write(0, 1);
    chk("R2 stop_req set", int'(stop_req), 1);
    do_write(1, 0);
    chk("R4 start while stop", int'(start_req), 0);
    do_write(0, 0);
    chk("R2 zero write", int'(stop_req), 1);
    do_tick();
    chk("R7 idle stop clear", int'(stop_req), 0);
    lines("R7 idle no activity", 0, 0);

    do_write(1, 0);
    chk("R2 start_req set", int'(start_req), 1);
    repeat (3) step();
    lines("R11 no tick", 0, 0);
    do_tick(); lines("R5 phase1", 1, 0);
    do_tick(); lines("R5 phase2", 1, 1);
    do_tick(); lines("R5 owned", 0, 1);
    chk("R5 start cleared", int'(start_req), 0);
    chk("R8 start_irq", int'(start_irq), 1);
    step();
    chk("R8 start_irq one cycle", int'(start_irq), 0);

    do_write(1, 0);
    do_tick(); lines("R6 release", 0, 0);
    do_tick(); lines("R6 phase1", 1, 0);
    do_tick(); lines("R6 phase2", 1, 1);
    tick = 1; wr_en = 1; wr_stop = 1;
    step();
    tick = 0; wr_en = 0; wr_stop = 0;
    chk("R4 collision start", int'(start_req), 0);
    chk("R4 collision stop dropped", int'(stop_req), 0);
    lines("R6 owned", 0, 1);

    do_write(0, 1);
    do_tick(); lines("R7 phase1", 1, 1);
    do_tick(); lines("R7 phase2", 1, 0);
    do_tick(); lines("R7 released", 0, 0);
    chk("R7 stop cleared", int'(stop_req), 0);

    bus_busy = 1; to_en = 1; to_limit = 8'd3;
    do_write(1, 0);
    do_tick(); step(); do_tick();
    chk("R9 still waiting", int'(start_req), 1);
    do_tick();
    chk("R9 timeout clears", int'(start_req), 0);
    chk("R9 to_irq", int'(to_irq), 1);
    lines("R9 lines idle", 0, 0);

    to_en = 0;
    do_write(1, 0);
    repeat (5) do_tick();
    chk("R9 disabled", int'(start_req), 1);
    master = 0;
    step();
    chk("R10 forced clear", int'(start_req), 0);
    do_write(1, 0);
    chk("R10 write ignored", int'(start_req), 0);
    master = 1; bus_busy = 0;
    step();

    for (int i = 0; i < 6000; i++) begin
      tick     = ($urandom_range(2) == 0);
      wr_en    = ($urandom_range(5) == 0);
      wr_start = $urandom_range(1);
      wr_stop  = ($urandom_range(3) == 0);
      if ($urandom_range(15) == 0) bus_busy = ~bus_busy;
      master   = ($urandom_range(60) != 0);
      enable   = ($urandom_range(80) != 0);
      if ($urandom_range(30) == 0) to_en = $urandom_range(1);
      if ($urandom_range(30) == 0) to_limit = 8'($urandom_range(5));
      start_irq_en = ($urandom_range(7) != 0);
      to_irq_en    = ($urandom_range(7) != 0);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule